// File: doc/BRIEF.md
# Priority I/O Pin Crossbar Decoder

This block decides which on-chip peripheral signal owns each pin of one eight-pin I/O port. The UART pair always sits on two fixed pins. The SMBus data and clock lines are always granted together. Every other enabled signal takes the lowest-numbered pin that is free and not masked by the skip vector. Any pin left without a peripheral signal becomes a general-purpose I/O pin.

From the per-pin assignment, the block builds the output data and output-enable multiplexers toward the pins. It also routes each pin's input level back to the peripheral signal that owns that pin. The assignment is held in a register, so a configuration change reaches the outputs after the next rising clock edge.

The block also reports which enabled signals could not be placed.

Top module: `io_xbar`

## Requirements
- R1: While the crossbar and the UART are enabled, pin 4 carries select code 1 (UART transmit) and pin 5 carries code 2 (UART receive). This holds even when the skip mask covers those pins. Both pins are reserved before any other signal is placed.
- R2: Enabling SMBus grants code 3 (data) to the lowest free unskipped pin and code 4 (clock) to the next one. If fewer than two such pins remain, neither code is granted and both are flagged as not placed.
- R3: A pin whose skip bit is set never carries a code other than 0, apart from the fixed UART pins of R1.
- R4: After UART and SMBus are placed, codes 5 to 13 are placed in ascending order. Auxiliary enable bit k enables code k+5 (5 comparator output, 6 comparator asynchronous output, 7 system clock out, 8 to 10 capture/compare channels 0 to 2, 11 external counter input, 12 timer 0 input, 13 timer 1 input). Each code takes the lowest pin that is unskipped and still free, and no code appears on more than one pin.
- R5: A pin left with code 0 reports a GPIO flag of 1. It drives the GPIO data and GPIO output-enable bits of that pin.
- R6: An enabled signal with code c that gets no pin raises bit c-1 of the not-placed vector, and no pin carries code c.
- R7: While the global enable is low, every pin is GPIO with code 0 and the not-placed vector is zero.
- R8: A pin with code c drives peripheral data bit c-1. Its output enable is peripheral output-enable bit c-1, except that the input-only codes 2, 11, 12 and 13 hold the output enable at 0.
- R9: Peripheral input bit c-1 equals the input level of the pin that carries code c. It reads 1 when no pin carries code c.
- R10: Configuration inputs reach the select, GPIO and not-placed outputs after one rising clock edge. After reset, all pins are GPIO and nothing is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xbar_en_i | input | 1 | Global crossbar enable |
| uart_en_i | input | 1 | UART pin pair enable |
| smb_en_i | input | 1 | SMBus pin pair enable |
| aux_en_i | input | 9 | Bit k enables code k+5 |
| skip_i | input | 8 | Pins the allocator passes over |
| periph_do_i | input | 13 | Peripheral output data, bit c-1 for code c |
| periph_oe_i | input | 13 | Peripheral output enable, bit c-1 for code c |
| gpio_do_i | input | 8 | GPIO output data per pin |
| gpio_oe_i | input | 8 | GPIO output enable per pin |
| pin_di_i | input | 8 | Pin input levels |
| pin_do_o | output | 8 | Pin output data |
| pin_oe_o | output | 8 | Pin output enable |
| pin_sel_o | output | 32 | Four-bit select code per pin, pin p at bits 4p+3:4p |
| pin_gpio_o | output | 8 | Pin is general-purpose I/O |
| periph_di_o | output | 13 | Pin input routed to each peripheral signal |
| unplaced_o | output | 13 | Enabled signal that found no pin |

## Verification
Several properties are checked on every cycle against the registered configuration: the fixed UART pins, the rule that skipped pins stay unassigned, the rule that each code appears on at most one pin, the pairing of the SMBus codes, the agreement of the not-placed flags with the select codes, the disabled state, and the output enable held low on input-only pins. Two things can only be shown by the bench's scenarios, which compare against a reference allocation: the exact pin each signal lands on under priority order, and the correct data and input routing. Those scenarios include an exhausted port, a lone free pin offered to the SMBus pair, and a skip mask that covers the UART pins.

// File: rtl/io_xbar_pkg.sv
package io_xbar_pkg;
  localparam int NSIG = 13;
  localparam int NAUX = 9;
  localparam int CW   = 4;
  localparam int AUX_BASE = 5;

  typedef logic [CW-1:0] code_t;

  localparam code_t C_GPIO = 4'd0;
  localparam code_t C_TX   = 4'd1;
  localparam code_t C_RX   = 4'd2;
  localparam code_t C_SDA  = 4'd3;
  localparam code_t C_SCL  = 4'd4;
  localparam code_t C_ECI  = 4'd11;
  localparam code_t C_T0   = 4'd12;
  localparam code_t C_T1   = 4'd13;

  function automatic logic is_input_only(code_t c);
    return (c == C_RX) || (c == C_ECI) || (c == C_T0) || (c == C_T1);
  endfunction
endpackage

// File: rtl/xbar_alloc.sv
module xbar_alloc
  import io_xbar_pkg::*;
#(
  parameter int NPIN   = 8,
  parameter int TX_PIN = 4,
  parameter int RX_PIN = 5
) (
  input  logic                     en_i,
  input  logic                     uart_en_i,
  input  logic                     smb_en_i,
  input  logic [NAUX-1:0]          aux_en_i,
  input  logic [NPIN-1:0]          skip_i,
  output logic [NPIN-1:0][CW-1:0]  sel_o,
  output logic [NSIG-1:0]          unplaced_o
);
  always_comb begin
    logic [NPIN-1:0] free;
    int              n;
    logic            found;
    sel_o      = '0;
    unplaced_o = '0;
    free       = ~skip_i;
    n          = 0;
    found      = 1'b0;
    if (en_i) begin
      // fixed UART pins reserved first
      if (uart_en_i) begin
        sel_o[TX_PIN] = C_TX;
        sel_o[RX_PIN] = C_RX;
        free[TX_PIN]  = 1'b0;
        free[RX_PIN]  = 1'b0;
      end
      if (smb_en_i) begin
        if ($countones(free) >= 2) begin
          n = 0;
          for (int p = 0; p < NPIN; p++) begin
            if (free[p] && n < 2) begin
              sel_o[p] = (n == 0) ? C_SDA : C_SCL;
              free[p]  = 1'b0;
              n        = n + 1;
            end
          end
        end else begin
          unplaced_o[C_SDA-1] = 1'b1;
          unplaced_o[C_SCL-1] = 1'b1;
        end
      end
      for (int k = 0; k < NAUX; k++) begin
        if (aux_en_i[k]) begin
          found = 1'b0;
          for (int p = 0; p < NPIN; p++) begin
            if (!found && free[p]) begin
              sel_o[p] = code_t'(k + AUX_BASE);
              free[p]  = 1'b0;
              found    = 1'b1;
            end
          end
          if (!found) unplaced_o[k + AUX_BASE - 1] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/xbar_pin_mux.sv
module xbar_pin_mux
  import io_xbar_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [NPIN-1:0][CW-1:0] sel_i,
  input  logic [NSIG-1:0]         periph_do_i,
  input  logic [NSIG-1:0]         periph_oe_i,
  input  logic [NPIN-1:0]         gpio_do_i,
  input  logic [NPIN-1:0]         gpio_oe_i,
  output logic [NPIN-1:0]         pin_do_o,
  output logic [NPIN-1:0]         pin_oe_o,
  output logic [NPIN-1:0]         pin_gpio_o
);
  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    always_comb begin
      int idx;
      idx           = int'(sel_i[p]) - 1;
      pin_do_o[p]   = gpio_do_i[p];
      pin_oe_o[p]   = gpio_oe_i[p];
      pin_gpio_o[p] = 1'b1;
      if (idx >= 0 && idx < NSIG) begin
        pin_gpio_o[p] = 1'b0;
        pin_do_o[p]   = periph_do_i[idx];
        pin_oe_o[p]   = is_input_only(sel_i[p]) ? 1'b0 : periph_oe_i[idx];
      end
    end
  end
endmodule

// File: rtl/xbar_in_route.sv
module xbar_in_route
  import io_xbar_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic [NPIN-1:0][CW-1:0] sel_i,
  input  logic [NPIN-1:0]         pin_di_i,
  output logic [NSIG-1:0]         periph_di_o
);
  for (genvar s = 0; s < NSIG; s++) begin : g_sig
    always_comb begin
      periph_di_o[s] = 1'b1;  // idle level when unrouted
      for (int p = 0; p < NPIN; p++) begin
        if (sel_i[p] == code_t'(s + 1)) periph_di_o[s] = pin_di_i[p];
      end
    end
  end
endmodule

// File: rtl/io_xbar.sv
module io_xbar
  import io_xbar_pkg::*;
#(
  parameter int NPIN    = 8,
  parameter int TX_PIN  = 4,
  parameter int RX_PIN  = 5,
  parameter bit REG_CFG = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               xbar_en_i,
  input  logic               uart_en_i,
  input  logic               smb_en_i,
  input  logic [NAUX-1:0]    aux_en_i,
  input  logic [NPIN-1:0]    skip_i,
  input  logic [NSIG-1:0]    periph_do_i,
  input  logic [NSIG-1:0]    periph_oe_i,
  input  logic [NPIN-1:0]    gpio_do_i,
  input  logic [NPIN-1:0]    gpio_oe_i,
  input  logic [NPIN-1:0]    pin_di_i,
  output logic [NPIN-1:0]    pin_do_o,
  output logic [NPIN-1:0]    pin_oe_o,
  output logic [NPIN*CW-1:0] pin_sel_o,
  output logic [NPIN-1:0]    pin_gpio_o,
  output logic [NSIG-1:0]    periph_di_o,
  output logic [NSIG-1:0]    unplaced_o
);
  logic [NPIN-1:0][CW-1:0] sel_d, sel_q;
  logic [NSIG-1:0]         unpl_d, unpl_q;

  xbar_alloc #(.NPIN(NPIN), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN)) u_alloc (
    .en_i       (xbar_en_i),
    .uart_en_i  (uart_en_i),
    .smb_en_i   (smb_en_i),
    .aux_en_i   (aux_en_i),
    .skip_i     (skip_i),
    .sel_o      (sel_d),
    .unplaced_o (unpl_d)
  );

  if (REG_CFG) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sel_q  <= '0;
        unpl_q <= '0;
      end else begin
        sel_q  <= sel_d;
        unpl_q <= unpl_d;
      end
    end
  end else begin : g_comb
    assign sel_q  = sel_d;
    assign unpl_q = unpl_d;
  end

  xbar_pin_mux #(.NPIN(NPIN)) u_mux (
    .sel_i       (sel_q),
    .periph_do_i (periph_do_i),
    .periph_oe_i (periph_oe_i),
    .gpio_do_i   (gpio_do_i),
    .gpio_oe_i   (gpio_oe_i),
    .pin_do_o    (pin_do_o),
    .pin_oe_o    (pin_oe_o),
    .pin_gpio_o  (pin_gpio_o)
  );

  xbar_in_route #(.NPIN(NPIN)) u_in (
    .sel_i       (sel_q),
    .pin_di_i    (pin_di_i),
    .periph_di_o (periph_di_o)
  );

  assign pin_sel_o  = sel_q;
  assign unplaced_o = unpl_q;
endmodule

// File: rtl/io_xbar_chk.sv
module io_xbar_chk
  import io_xbar_pkg::*;
#(
  parameter int NPIN    = 8,
  parameter int TX_PIN  = 4,
  parameter int RX_PIN  = 5,
  parameter bit REG_CFG = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               xbar_en_i,
  input logic               uart_en_i,
  input logic [NPIN-1:0]    skip_i,
  input logic [NPIN-1:0]    gpio_oe_i,
  input logic [NPIN-1:0]    pin_oe_o,
  input logic [NPIN*CW-1:0] pin_sel_o,
  input logic [NPIN-1:0]    pin_gpio_o,
  input logic [NSIG-1:0]    unplaced_o
);
  logic            c_en, c_uart;
  logic [NPIN-1:0] c_skip;

  // configuration as seen by the outputs
  if (REG_CFG) begin : g_mirror
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        c_en   <= 1'b0;
        c_uart <= 1'b0;
        c_skip <= '0;
      end else begin
        c_en   <= xbar_en_i;
        c_uart <= uart_en_i;
        c_skip <= skip_i;
      end
    end
  end else begin : g_direct
    assign c_en   = xbar_en_i;
    assign c_uart = uart_en_i;
    assign c_skip = skip_i;
  end

  logic [NSIG:1][NPIN-1:0] hit;
  for (genvar c = 1; c <= NSIG; c++) begin : g_code
    for (genvar p = 0; p < NPIN; p++) begin : g_p
      assign hit[c][p] = (pin_sel_o[p*CW +: CW] == code_t'(c));
    end
    a_r4_code_unique: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(hit[c]));
    a_r6_unplaced_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
      unplaced_o[c-1] |-> (hit[c] == '0));
  end

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    a_r3_skip_unassigned: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (c_skip[p] && !(c_en && c_uart && (p == TX_PIN || p == RX_PIN)))
      |-> (pin_sel_o[p*CW +: CW] == C_GPIO));
    a_r8_input_only_no_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
      is_input_only(pin_sel_o[p*CW +: CW]) |-> !pin_oe_o[p]);
  end

  a_r1_uart_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_en && c_uart) |-> (pin_sel_o[TX_PIN*CW +: CW] == C_TX &&
                          pin_sel_o[RX_PIN*CW +: CW] == C_RX));

  a_r2_smb_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit[C_SDA]) == $countones(hit[C_SCL]));

  a_r7_disabled_gpio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !c_en |-> (&pin_gpio_o && pin_oe_o == gpio_oe_i && unplaced_o == '0));
endmodule

bind io_xbar io_xbar_chk #(
  .NPIN(NPIN), .TX_PIN(TX_PIN), .RX_PIN(RX_PIN), .REG_CFG(REG_CFG)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .xbar_en_i  (xbar_en_i),
  .uart_en_i  (uart_en_i),
  .skip_i     (skip_i),
  .gpio_oe_i  (gpio_oe_i),
  .pin_oe_o   (pin_oe_o),
  .pin_sel_o  (pin_sel_o),
  .pin_gpio_o (pin_gpio_o),
  .unplaced_o (unplaced_o)
);

// File: tb/io_xbar_tb.sv
`timescale 1ns/1ps
module io_xbar_tb;
  localparam real TCLK = 20.0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en, uart, smb;
  logic [8:0]  aux;
  logic [7:0]  skip, gdo, goe, pdi;
  logic [12:0] pdo, poe;
  logic [7:0]  pin_do, pin_oe, pin_gpio;
  logic [31:0] pin_sel;
  logic [12:0] periph_di, unplaced;
  int checks = 0, errors = 0;

  always #(TCLK/2) clk = ~clk;

  io_xbar u_dut (
    .clk_i(clk), .rst_ni(rst_n), .xbar_en_i(en), .uart_en_i(uart), .smb_en_i(smb),
    .aux_en_i(aux), .skip_i(skip), .periph_do_i(pdo), .periph_oe_i(poe),
    .gpio_do_i(gdo), .gpio_oe_i(goe), .pin_di_i(pdi), .pin_do_o(pin_do),
    .pin_oe_o(pin_oe), .pin_sel_o(pin_sel), .pin_gpio_o(pin_gpio),
    .periph_di_o(periph_di), .unplaced_o(unplaced)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic void model(input logic e, u, s, input logic [8:0] ax,
                                input logic [7:0] sk, output logic [31:0] sel,
                                output logic [12:0] unpl);
    logic [7:0] fr;
    int n;
    sel = '0; unpl = '0; fr = ~sk;
    if (!e) return;
    if (u) begin sel[16 +: 4] = 4'd1; sel[20 +: 4] = 4'd2; fr[4] = 0; fr[5] = 0; end
    if (s) begin
      if ($countones(fr) >= 2) begin
        n = 0;
        for (int p = 0; p < 8; p++)
          if (fr[p] && n < 2) begin
            sel[p*4 +: 4] = (n == 0) ? 4'd3 : 4'd4; fr[p] = 0; n++;
          end
      end else begin unpl[2] = 1; unpl[3] = 1; end
    end
    for (int k = 0; k < 9; k++) if (ax[k]) begin
      n = -1;
      for (int p = 0; p < 8; p++) if (n < 0 && fr[p]) n = p;
      if (n < 0) unpl[k+4] = 1;
      else begin sel[n*4 +: 4] = 4'(k + 5); fr[n] = 0; end
    end
  endfunction

  task automatic verify_all(input string tag);
    logic [31:0] es; logic [12:0] eu;
    logic [7:0] edo, eoe, egp; logic [12:0] edi;
    int c;
    model(en, uart, smb, aux, skip, es, eu);
    edi = '1;
    for (int p = 0; p < 8; p++) begin
      c = int'(es[p*4 +: 4]);
      egp[p] = (c == 0);
      if (c == 0) begin edo[p] = gdo[p]; eoe[p] = goe[p]; end
      else begin
        edo[p] = pdo[c-1];
        eoe[p] = (c == 2 || c >= 11) ? 1'b0 : poe[c-1];
        edi[c-1] = pdi[p];
      end
    end
    check({tag, " R4 select"}, pin_sel, es);
    check({tag, " R6 unplaced"}, 32'(unplaced), 32'(eu));
    check({tag, " R5 gpio"}, 32'(pin_gpio), 32'(egp));
    check({tag, " R8 do"}, 32'(pin_do), 32'(edo));
    check({tag, " R8 oe"}, 32'(pin_oe), 32'(eoe));
    check({tag, " R9 di"}, 32'(periph_di), 32'(edi));
  endtask

  task automatic apply(input logic e, u, s, input logic [8:0] ax, input logic [7:0] sk);
    @(negedge clk);
    en = e; uart = u; smb = s; aux = ax; skip = sk;
    pdo = 13'($urandom); poe = 13'($urandom);
    gdo = 8'($urandom); goe = 8'($urandom); pdi = 8'($urandom);
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(TCLK * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    en = 1; uart = 1; smb = 1; aux = '1; skip = '0;
    pdo = '0; poe = '1; gdo = '0; goe = '0; pdi = '0;
    #(TCLK * 3);
    check("R10 reset select", pin_sel, 32'h0);
    check("R10 reset gpio", 32'(pin_gpio), 32'hFF);
    check("R10 reset unplaced", 32'(unplaced), 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 example: pins 0,3 skipped, UART+SMBus+clock out
    apply(1, 1, 1, 9'b000000100, 8'h09);
    check("R2 example layout", pin_sel, 32'h0721_0430);
    verify_all("example");

    // R6 port exhausted
    apply(1, 1, 1, 9'h1FF, 8'h00);
    check("R6 exhausted unplaced", 32'(unplaced), 32'h1F00);
    check("R4 exhausted layout", pin_sel, 32'h8721_6543);

    // R2 single free pin
    apply(1, 0, 1, 9'b000000001, 8'hFE);
    check("R2 lone pin", pin_sel, 32'h0000_0005);
    check("R2 lone pin unplaced", 32'(unplaced), 32'h000C);

    // R1 UART overrides skip, R3 other skipped pins stay GPIO
    apply(1, 1, 0, 9'h1FF, 8'hFF);
    check("R1 uart fixed", pin_sel, 32'h0021_0000);
    check("R3 skipped pins", 32'(pin_gpio), 32'hCF);

    // R7 disabled
    apply(0, 1, 1, 9'h1FF, 8'h00);
    check("R7 disabled select", pin_sel, 32'h0);
    check("R7 disabled oe", 32'(pin_oe), 32'(goe));
    check("R7 disabled unplaced", 32'(unplaced), 32'h0);

    // R10 one-edge latency
    @(negedge clk);
    en = 1; uart = 0; smb = 0; aux = 9'b000000001; skip = 8'h00;
    #(TCLK / 4);
    check("R10 before edge", pin_sel, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R10 after edge", pin_sel, 32'h0000_0005);

    for (int i = 0; i < 400; i++) begin
      apply(($urandom % 8) != 0, 1'($urandom), 1'($urandom), 9'($urandom), 8'($urandom));
      verify_all("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule